// File: doc/BRIEF.md
# Ternary Learning Associative Match Array

The block stores a set of binary image templates and checks a new image against all of them at once. It holds a number of slices. Each slice is a grid of one-bit cells, and each cell keeps two flags: "seen a one" and "seen a zero". During learning, a one-hot slice select picks the target slice. Each image loaded while the load strobe is high ORs its pixels into the "seen one" flags and ORs its inverted pixels into the "seen zero" flags. Several typefaces of one character are loaded into the same slice in turn. Each cell then ends up with one of three meanings: always one, always zero, or don't care (both flags set). A cell with neither flag set is untrained and never matches.

During compare, every cell of every slice judges the applied image in the same cycle. All cell results within a slice are ANDed, and the per-slice results are captured into a match register at the clock edge where compare is high. The register keeps its value until the next compare. A priority encoder turns the register into a character code taken from an arithmetic code table (slice k gives `CODE_BASE + k`). It also gives a valid flag and a multiple-match flag.

Each cycle a command decoder picks one of three operations from the two strobes. OP_IDLE is chosen when neither strobe is high. OP_LEARN is chosen when only load is high. OP_MATCH is chosen when compare is high, whatever load is. The operation is chosen afresh every cycle, and any operation may follow any other. Per-slice clears act alongside whichever operation is chosen.

Top module: `tma_top`

## Requirements
- R1: While the active-low reset is low, and after it is released, every cell is untrained (both flags 0), the match register is 0, code_valid and multi_match are 0, and code is 0.
- R2: At a clock edge with load=1 and comp=0, every cell of each slice whose select bit is 1 sets its seen-one flag if its pixel is 1 and its seen-zero flag if its pixel is 0. Flags already set stay set.
- R3: A slice whose select bit is 0 keeps its cell state through a load cycle.
- R4: A slice's match bit is 1 only if every cell agrees with the image. A cell agrees when its pixel is 1 and the cell has seen a one, or when its pixel is 0 and the cell has seen a zero. Pixel (row r, column c) is image bit r*COLS+c. A slice with no training images never matches, and a slice trained with both an all-zero and an all-one image matches every image.
- R5: All slices are compared in the same cycle. Slice k's result is written to match_reg bit k at the clock edge where comp=1, and it is visible on the outputs straight after that edge.
- R6: While comp=0, match_reg keeps its value, whatever the changes on image, load or select.
- R7: When load and comp are both 1 in a cycle, the load has no effect on any cell. The compare still takes place.
- R8: At a clock edge where slice_clr bit k is 1, every cell of slice k returns to untrained, even if a load to slice k happens in the same cycle. Other slices are not affected.
- R9: code shows CODE_BASE + k for the lowest-numbered set bit k of match_reg (default CODE_BASE is 0x41), and code_valid is 1. When match_reg is 0, code_valid is 0 and code is 0.
- R10: multi_match is 1 exactly when two or more bits of match_reg are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| image | input | ROWS*COLS | Flattened binary image, pixel (r,c) at bit r*COLS+c |
| slice_sel | input | SLICES | One-hot select of the slice to be trained |
| load | input | 1 | Learning strobe |
| comp | input | 1 | Compare strobe; takes priority over load |
| slice_clr | input | SLICES | Per-slice return to untrained |
| match_reg | output | SLICES | Captured per-slice match results |
| code | output | CODE_W | Code of the lowest matching slice |
| code_valid | output | 1 | At least one slice matched |
| multi_match | output | 1 | Two or more slices matched |

## Verification
The hardest state to reach from the ports is a mix of trained slices in which some cells are don't-care, some are strict and others are untrained. In that state a single flipped pixel must flip exactly the slices that its cells constrain. The bench gets there in two steps. First it loads a distinct image into each slice. Then it loads a second, partly changed image into some slices. After that it sweeps every single-pixel flip of every template. Multiple matches need slices that accept everything, so two slices are given an all-zero and an all-one image and the sweep is repeated. The load-during-compare collision and the clear-during-load collision are each driven with an image that would visibly change a template, so any leak shows up in the compares that follow.

// File: rtl/tma_pkg.sv
package tma_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_LEARN = 2'd1,
        OP_MATCH = 2'd2
    } op_t;

endpackage

// File: rtl/tma_cell.sv
module tma_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic learn,
    input  logic pix,
    output logic hit
);

    logic seen_one;
    logic seen_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_one  <= 1'b0;
            seen_zero <= 1'b0;
        end else if (clr) begin
            seen_one  <= 1'b0;
            seen_zero <= 1'b0;
        end else if (learn) begin
            seen_one  <= seen_one | pix;
            seen_zero <= seen_zero | ~pix;
        end
    end

    always_comb begin
        hit = (seen_zero & ~pix) | (seen_one & pix);
    end

    // R8: a clear leaves the cell untrained
    a_r8_clear_untrained: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!seen_one && !seen_zero));

    // R2: learning a one sets the seen-one flag
    a_r2_learn_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (learn && !clr && pix) |=> seen_one);

    // R2: flags never drop without a clear
    a_r2_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && seen_zero) |=> seen_zero);

endmodule

// File: rtl/tma_slice.sv
module tma_slice #(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    localparam int PIX = ROWS * COLS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           learn,
    input  logic [PIX-1:0] image,
    output logic           hit
);

    logic [PIX-1:0] cell_hit;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            tma_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (clr),
                .learn (learn),
                .pix   (image[r*COLS+c]),
                .hit   (cell_hit[r*COLS+c])
            );
        end
    end

    always_comb begin
        hit = &cell_hit;
    end

endmodule

// File: rtl/tma_encoder.sv
module tma_encoder #(
    parameter int SLICES = 8,
    parameter int CODE_W = 8,
    parameter logic [CODE_W-1:0] CODE_BASE = CODE_W'(8'h41)
) (
    input  logic [SLICES-1:0] match,
    output logic [CODE_W-1:0] code,
    output logic              valid,
    output logic              multi
);

    always_comb begin
        code  = '0;
        valid = 1'b0;
        for (int k = SLICES - 1; k >= 0; k--) begin
            if (match[k]) begin
                code  = CODE_BASE + CODE_W'(k);
                valid = 1'b1;
            end
        end
        multi = |(match & (match - SLICES'(1)));
    end

    // R9: no valid means an all-zero code
    always_comb begin
        a_r9_idle_code: assert (valid || (code == '0));
    end

endmodule

// File: rtl/tma_top.sv
module tma_top #(
    parameter int ROWS   = 8,
    parameter int COLS   = 8,
    parameter int SLICES = 8,
    parameter int CODE_W = 8,
    parameter logic [CODE_W-1:0] CODE_BASE = CODE_W'(8'h41),
    localparam int PIX = ROWS * COLS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX-1:0]    image,
    input  logic [SLICES-1:0] slice_sel,
    input  logic              load,
    input  logic              comp,
    input  logic [SLICES-1:0] slice_clr,
    output logic [SLICES-1:0] match_reg,
    output logic [CODE_W-1:0] code,
    output logic              code_valid,
    output logic              multi_match
);

    import tma_pkg::*;

    op_t               op;
    logic [SLICES-1:0] slice_learn;
    logic [SLICES-1:0] slice_hit;

    // per-cycle command decode; compare wins over load
    always_comb begin
        unique case ({load, comp})
            2'b00:   op = OP_IDLE;
            2'b10:   op = OP_LEARN;
            2'b01:   op = OP_MATCH;
            2'b11:   op = OP_MATCH;
            default: op = OP_IDLE;
        endcase
    end

    always_comb begin
        for (int k = 0; k < SLICES; k++) begin
            slice_learn[k] = (op == OP_LEARN) && slice_sel[k];
        end
    end

    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        tma_slice #(
            .ROWS (ROWS),
            .COLS (COLS)
        ) u_slice (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (slice_clr[s]),
            .learn (slice_learn[s]),
            .image (image),
            .hit   (slice_hit[s])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_reg <= '0;
        end else if (op == OP_MATCH) begin
            match_reg <= slice_hit;
        end
    end

    tma_encoder #(
        .SLICES    (SLICES),
        .CODE_W    (CODE_W),
        .CODE_BASE (CODE_BASE)
    ) u_enc (
        .match (match_reg),
        .code  (code),
        .valid (code_valid),
        .multi (multi_match)
    );

    // R5: a compare edge captures the slice results
    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        comp |=> (match_reg == $past(slice_hit)));

    // R6: the register holds between compares
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !comp |=> $stable(match_reg));

    // R7: no slice learns during a compare
    a_r7_no_learn_in_compare: assert property (@(posedge clk) disable iff (!rst_n)
        comp |-> (slice_learn == '0));

    // R10: a multiple match implies a valid code
    a_r10_multi_valid: assert property (@(posedge clk) disable iff (!rst_n)
        multi_match |-> code_valid);

endmodule

// File: tb/tma_top_bench.sv
`timescale 1ns/100ps
module tma_top_bench;

    localparam int ROWS = 8;
    localparam int COLS = 8;
    localparam int NS   = 8;
    localparam int NP   = ROWS * COLS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] image = '0;
    logic [NS-1:0] slice_sel = '0;
    logic          load = 1'b0;
    logic          comp = 1'b0;
    logic [NS-1:0] slice_clr = '0;
    logic [NS-1:0] match_reg;
    logic [7:0]    code;
    logic          code_valid;
    logic          multi_match;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [NP-1:0] m_one  [NS];
    logic [NP-1:0] m_zero [NS];
    logic [NS-1:0] m_match;

    always #2.5 clk = ~clk;

    tma_top #(.ROWS(ROWS), .COLS(COLS), .SLICES(NS)) u_tma_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .image       (image),
        .slice_sel   (slice_sel),
        .load        (load),
        .comp        (comp),
        .slice_clr   (slice_clr),
        .match_reg   (match_reg),
        .code        (code),
        .code_valid  (code_valid),
        .multi_match (multi_match)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NP-1:0] pat(input int k);
        logic [63:0] v;
        v = 64'h9E3779B97F4A7C15 * 64'(k + 3);
        return v ^ (v >> 29);
    endfunction

    function automatic logic [NS-1:0] model_hits(input logic [NP-1:0] img);
        logic [NS-1:0] r;
        for (int s = 0; s < NS; s++) begin
            r[s] = 1'b1;
            for (int p = 0; p < NP; p++) begin
                if (img[p] && !m_one[s][p])  r[s] = 1'b0;
                if (!img[p] && !m_zero[s][p]) r[s] = 1'b0;
            end
        end
        return r;
    endfunction

    // one clock: inputs applied at negedge, results sampled at the next negedge
    task automatic cyc(input logic [NP-1:0] img, input logic [NS-1:0] sel,
                       input logic ld, input logic cp, input logic [NS-1:0] clr);
        image = img; slice_sel = sel; load = ld; comp = cp; slice_clr = clr;
        if (cp) m_match = model_hits(img);
        for (int s = 0; s < NS; s++) begin
            if (clr[s]) begin
                m_one[s] = '0; m_zero[s] = '0;
            end else if (ld && !cp && sel[s]) begin
                m_one[s] = m_one[s] | img;
                m_zero[s] = m_zero[s] | ~img;
            end
        end
        @(posedge clk);
        @(negedge clk);
        load = 1'b0; comp = 1'b0; slice_clr = '0; slice_sel = '0;
    endtask

    task automatic check_outputs();
        logic [7:0] ecode;
        logic       evalid;
        int         cnt;
        ecode = 8'h00; evalid = 1'b0; cnt = 0;
        for (int k = NS - 1; k >= 0; k--) begin
            if (m_match[k]) begin ecode = 8'h41 + 8'(k); evalid = 1'b1; end
        end
        for (int k = 0; k < NS; k++) cnt += int'(m_match[k]);
        chk("R4/R5 match_reg", 64'(match_reg), 64'(m_match));
        chk("R9 code", 64'(code), 64'(ecode));
        chk("R9 code_valid", 64'(code_valid), 64'(evalid));
        chk("R10 multi_match", 64'(multi_match), 64'(cnt > 1));
    endtask

    task automatic compare(input logic [NP-1:0] img);
        cyc(img, '0, 1'b0, 1'b1, '0);
        check_outputs();
    endtask

    task automatic learn(input int s, input logic [NP-1:0] img);
        cyc(img, NS'(1) << s, 1'b1, 1'b0, '0);
    endtask

    task automatic sweep();
        for (int s = 0; s < NS; s++) begin
            logic [NP-1:0] base;
            base = pat(s);
            compare(base);
            for (int p = 0; p < NP; p++) compare(base ^ (NP'(1) << p));
            // R6: an idle cycle with a different image keeps the register
            cyc(~base, 8'hFF, 1'b0, 1'b0, '0);
            check_outputs();
        end
    endtask

    initial begin
        for (int s = 0; s < NS; s++) begin m_one[s] = '0; m_zero[s] = '0; end
        m_match = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 match_reg", 64'(match_reg), 64'h0);
        chk("R1 code", 64'(code), 64'h0);
        chk("R1 code_valid", 64'(code_valid), 64'h0);
        chk("R1 multi_match", 64'(multi_match), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: untrained slices never match, not even the all-zero image
        compare('0);
        compare({NP{1'b1}});
        // R2: one strict template per slice
        for (int s = 0; s < NS; s++) learn(s, pat(s));
        // R2: a second typeface makes some cells don't-care
        for (int s = 0; s < 4; s++) learn(s, pat(s) ^ (64'h0000_F000_0000_00FF << s));
        // R3: load with no slice selected changes nothing
        cyc(~pat(5), '0, 1'b1, 1'b0, '0);
        // R7: load together with compare is ignored, compare still happens
        cyc(~pat(4), NS'(1) << 4, 1'b1, 1'b1, '0);
        check_outputs();
        sweep();
        // R4/R10: slices 6 and 7 become all don't-care
        learn(6, '0); learn(6, {NP{1'b1}});
        learn(7, {NP{1'b1}}); learn(7, '0);
        sweep();
        compare(64'h0123_4567_89AB_CDEF);
        // R8: clear beats a load in the same cycle, other slices keep state
        cyc(~pat(6), NS'(1) << 6, 1'b1, 1'b0, NS'(1) << 6);
        compare(pat(2));
        compare(~pat(6));
        cyc('0, '0, 1'b0, 1'b0, NS'(1) << 7);
        compare(64'h0123_4567_89AB_CDEF);
        sweep();
        // R8/R9: clear everything, nothing matches
        cyc('0, '0, 1'b0, 1'b0, {NS{1'b1}});
        compare(pat(1));
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule